// File: doc/BRIEF.md
# Multi-Phase Clock Divider with Half-Step Shift

This block turns one reference clock, running at twice the master rate, into the group of derived clocks and strobes that a sensor readout chain uses. It produces a serializer clock at master rate, a checksum clock at one quarter of master rate, and a load strobe at one quarter of master rate. It also produces a converter clock at one eighth of master rate. All four come from one shared phase counter, so their rising edges line up.

Two further outputs can be moved in time. The first is a sensor clock at one quarter of master rate. The second is a converter clock at one eighth of master rate. Each is delayed by a code held in an 8-bit configuration input. One reference period equals half a master period, so each code step moves the clock by half a master period. There are 15 usable settings, 0 to 14.

A code written on the configuration input does not act at once. It is captured only at the boundary of the eighth-rate period. Every output comes straight from a flop clocked by the reference, so every edge falls on a half-master-period boundary. The block has no data stream, so all of its pins are plain control pins and none of them uses a handshake.

Top module: `msclk_divider`

## Requirements
- R1: While `rst_i` is high at a reference edge, every output is low after that edge and both delay codes in use return to 0. After the release of reset, the phase counter starts from 0.
- R2: `ser_clk_o` toggles on every reference edge. It goes high on the first edge after reset is released, so its period is one master period.
- R3: `chk_clk_o` is high for 4 reference cycles and then low for 4. Its first high phase starts on the first edge after reset is released.
- R4: `load_o` is high for exactly 1 reference cycle in every 8, which is half a master period out of four master periods. It goes high on the same edge as each rising edge of `chk_clk_o`.
- R5: `afe_clk_o` is high for 8 reference cycles and then low for 8. Each of its rising edges coincides with a rising edge of `chk_clk_o` and with a high `load_o`.
- R6: Take n as the number of reference edges since reset was released, counted from 0, and d as the sensor delay code in use. After edge n, `sen_clk_o` is high exactly when (n − d) mod 8 < 4. The code is the low nibble, `cfg_i[3:0]`.
- R7: Take e as the converter delay code in use. After edge n, `adc_clk_o` is high exactly when (n − e) mod 16 < 8. The code is the high nibble, `cfg_i[7:4]`.
- R8: A nibble value of 15 behaves exactly like 14. The delay code in use never exceeds 14.
- R9: A nibble value is captured only at an edge with n mod 16 = 15. It first affects the outputs at the next edge, which is a rising edge of `afe_clk_o`. Changes to `cfg_i` at any other edge have no effect on the outputs until that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Reference clock at twice the master rate |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_i | input | 8 | Delay codes: [3:0] for the sensor clock, [7:4] for the adjustable converter clock |
| ser_clk_o | output | 1 | Serializer clock, master rate |
| chk_clk_o | output | 1 | Checksum clock, quarter rate |
| load_o | output | 1 | Load strobe, quarter rate, 12.5% duty |
| afe_clk_o | output | 1 | Fixed converter clock, eighth rate |
| sen_clk_o | output | 1 | Shiftable sensor clock, quarter rate |
| adc_clk_o | output | 1 | Shiftable converter clock, eighth rate |

## Verification
The assertions assume that reset is synchronous to the reference and held for at least one edge. They also assume that `cfg_i` only has to be stable at reference edges. Under those conditions, the captured codes change only at the eighth-rate boundary. The stimulus changes `cfg_i` only on falling edges of the reference. It places many of these changes away from the capture edge, so the delay that was in force earlier must persist. It includes codes of 15 in both nibbles, and it also applies reset in the middle of a run.

// File: rtl/msclk_pkg.sv
package msclk_pkg;
  // index of the shiftable clock lanes
  typedef enum int {
    LANE_SEN = 0,
    LANE_ADC = 1
  } lane_e;
  localparam int N_LANES = 2;
endpackage

// File: rtl/msclk_phase_ctr.sv
module msclk_phase_ctr #(
  parameter int PH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  output logic [PH_W-1:0] cnt_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] LAST = '1;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_o <= '0;
    else       cnt_o <= cnt_o + 1'b1;
  end

  assign wrap_o = (cnt_o == LAST);

  // R1
  counter_restart_chk: assert property (@(posedge clk_i) rst_i |=> cnt_o == '0);
endmodule

// File: rtl/msclk_code_latch.sv
module msclk_code_latch #(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 14
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wrap_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] act_o
);
  localparam logic [CODE_W-1:0] CAP = CODE_W'(MAX_CODE);

  logic [CODE_W-1:0] sat_code;
  assign sat_code = (code_i > CAP) ? CAP : code_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)       act_o <= '0;
    else if (wrap_i) act_o <= sat_code;
  end

  // R9
  code_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_i |=> $stable(act_o));
  // R8
  code_cap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    act_o <= CAP);
endmodule

// File: rtl/msclk_shift_clk.sv
module msclk_shift_clk #(
  parameter int PER_W  = 3,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [PER_W-1:0]  cnt_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o
);
  localparam int DW = PER_W + CODE_W;

  logic [DW-1:0] diff;
  assign diff = {{CODE_W{1'b0}}, cnt_i} - {{PER_W{1'b0}}, code_i};

  // high during the first half of the shifted period
  always_ff @(posedge clk_i) begin
    if (rst_i) clk_o <= 1'b0;
    else       clk_o <= ~diff[PER_W-1];
  end
endmodule

// File: rtl/msclk_divider.sv
module msclk_divider #(
  parameter int PH_W     = 4,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 14
) (
  input  logic              clk2x_i,
  input  logic              rst_i,
  input  logic [2*CODE_W-1:0] cfg_i,
  output logic              ser_clk_o,
  output logic              chk_clk_o,
  output logic              load_o,
  output logic              afe_clk_o,
  output logic              sen_clk_o,
  output logic              adc_clk_o
);
  import msclk_pkg::*;

  localparam int QTR_W = PH_W - 1;

  logic [PH_W-1:0]   cnt;
  logic              wrap;
  logic [N_LANES-1:0] lane_clk;

  msclk_phase_ctr #(.PH_W(PH_W)) ctr_i (
    .clk_i(clk2x_i), .rst_i(rst_i), .cnt_o(cnt), .wrap_o(wrap)
  );

  // fixed-phase outputs share the counter
  msclk_shift_clk #(.PER_W(1), .CODE_W(CODE_W)) ser_i (
    .clk_i(clk2x_i), .rst_i(rst_i), .cnt_i(cnt[0:0]), .code_i('0), .clk_o(ser_clk_o)
  );
  msclk_shift_clk #(.PER_W(QTR_W), .CODE_W(CODE_W)) chk_i (
    .clk_i(clk2x_i), .rst_i(rst_i), .cnt_i(cnt[QTR_W-1:0]), .code_i('0), .clk_o(chk_clk_o)
  );
  msclk_shift_clk #(.PER_W(PH_W), .CODE_W(CODE_W)) afe_i (
    .clk_i(clk2x_i), .rst_i(rst_i), .cnt_i(cnt), .code_i('0), .clk_o(afe_clk_o)
  );

  always_ff @(posedge clk2x_i) begin
    if (rst_i) load_o <= 1'b0;
    else       load_o <= (cnt[QTR_W-1:0] == '0);
  end

  // shiftable lanes: code capture plus shifted divider
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    localparam int LW = (l == LANE_SEN) ? QTR_W : PH_W;
    logic [CODE_W-1:0] act;

    msclk_code_latch #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) lat_i (
      .clk_i(clk2x_i), .rst_i(rst_i), .wrap_i(wrap),
      .code_i(cfg_i[l*CODE_W +: CODE_W]), .act_o(act)
    );
    msclk_shift_clk #(.PER_W(LW), .CODE_W(CODE_W)) sh_i (
      .clk_i(clk2x_i), .rst_i(rst_i), .cnt_i(cnt[LW-1:0]), .code_i(act),
      .clk_o(lane_clk[l])
    );
  end

  assign sen_clk_o = lane_clk[LANE_SEN];
  assign adc_clk_o = lane_clk[LANE_ADC];

  // R1
  reset_low_chk: assert property (@(posedge clk2x_i) rst_i |=>
    !(ser_clk_o | chk_clk_o | load_o | afe_clk_o | sen_clk_o | adc_clk_o));
  // R2
  ser_toggle_chk: assert property (@(posedge clk2x_i) disable iff (rst_i)
    ser_clk_o |=> !ser_clk_o);
  // R2
  ser_rise_chk: assert property (@(posedge clk2x_i) disable iff (rst_i)
    !ser_clk_o |=> ser_clk_o);
  // R4
  load_narrow_chk: assert property (@(posedge clk2x_i) disable iff (rst_i)
    load_o |=> !load_o);
  // R4
  load_in_chk_chk: assert property (@(posedge clk2x_i) disable iff (rst_i)
    load_o |-> chk_clk_o);
  // R5
  afe_align_chk: assert property (@(posedge clk2x_i) disable iff (rst_i)
    $rose(afe_clk_o) |-> load_o && ser_clk_o);
endmodule

// File: tb/msclk_divider_tb_top.sv
module msclk_divider_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic [7:0] cfg;
  logic ser, chk, ld, afe, sen, adc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  int  n_m;
  int  ds_m, da_m;
  logic e_ser, e_chk, e_ld, e_afe, e_sen, e_adc;

  always #5 clk = ~clk;

  msclk_divider dut_i (
    .clk2x_i(clk), .rst_i(rst), .cfg_i(cfg),
    .ser_clk_o(ser), .chk_clk_o(chk), .load_o(ld), .afe_clk_o(afe),
    .sen_clk_o(sen), .adc_clk_o(adc)
  );

  function automatic int sat14(input logic [3:0] v);
    return (v == 4'd15) ? 14 : int'(v);
  endfunction

  function automatic logic shifted_high(input int n, input int d, input int per);
    int m;
    m = ((n - d) % per + per) % per;
    return (m < per / 2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {e_ser, e_chk, e_ld, e_afe, e_sen, e_adc} <= '0;
      n_m <= 0; ds_m <= 0; da_m <= 0;
    end else begin
      e_ser <= shifted_high(n_m, 0, 2);
      e_chk <= shifted_high(n_m, 0, 8);
      e_ld  <= (n_m % 8 == 0);
      e_afe <= shifted_high(n_m, 0, 16);
      e_sen <= shifted_high(n_m, ds_m, 8);
      e_adc <= shifted_high(n_m, da_m, 16);
      if (n_m % 16 == 15) begin
        ds_m <= sat14(cfg[3:0]);
        da_m <= sat14(cfg[7:4]);
      end
      n_m <= n_m + 1;
    end
  end

  task automatic check(input string req, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at t=%0t: actual=%b expected=%b", req, name, $time, act, exp);
    end
  endtask

  task automatic check_all(input string adj_req);
    check("R2", "ser", ser, e_ser);
    check("R3", "chk", chk, e_chk);
    check("R4", "load", ld, e_ld);
    check("R5", "afe", afe, e_afe);
    check({"R6 ", adj_req}, "sen", sen, e_sen);
    check({"R7 ", adj_req}, "adc", adc, e_adc);
  endtask

  task automatic run(input int cycles, input string adj_req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_all(adj_req);
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      // R1
      check("R1", "all-low", |{ser, chk, ld, afe, sen, adc}, 1'b0);
    end
    rst = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(100_000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    cfg = 8'h00;
    do_reset(4);
    run(64, "R9");
    // directed codes, including saturation
    cfg = 8'h37; run(64, "R9");
    cfg = 8'hEE; run(64, "R9");
    cfg = 8'hFF; run(64, "R8");
    cfg = 8'hF0; run(48, "R8");
    cfg = 8'h0F; run(48, "R8");
    // reset in mid-run clears codes
    cfg = 8'h5A;
    run(21, "R9");
    do_reset(3);
    run(40, "R1");
    // random code changes at arbitrary cycles
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      check_all("R9");
      if ($urandom_range(0, 5) == 0) cfg = 8'($urandom);
      if ($urandom_range(0, 399) == 0) begin
        rst = 1'b1;
        @(negedge clk);
        check("R1", "all-low", |{ser, chk, ld, afe, sen, adc}, 1'b0);
        rst = 1'b0;
      end
    end
    summary();
  end
endmodule